// File: doc/BRIEF.md
# Double-Buffered Serial Master Port

This block is a master-only, full-duplex synchronous serial port with three wires: a serial clock it always drives, a data output and a data input. Frames are eight bits long and leave most significant bit first, while a byte is sampled from the input line during the same frame. A single shift register sits between a transmit holding buffer and a receive holding buffer. Bytes pass from the transmit buffer into the shifter, and from the shifter into the receive buffer, without any help from software. Single bytes and unbroken streams therefore both work.

The bit rate comes from an input clock-enable pulse. Each pulse toggles the serial clock, so one bit period lasts two pulses and the duty cycle is 50%. Software works through a four-register read/write port. The data address is shared: a write fills the transmit buffer and a read returns the receive buffer. Status flags and a mask register drive three registered interrupt lines: receive full, transmit empty and transmission done.

Top module: `ssm_top`

## Requirements
- R1: The block is always master. `sclk` is an output, it idles low, and it rises only while a frame is in progress.
- R2: `sclk` changes level only on cycles where `tick` is high. Within a frame, consecutive rising edges are exactly two ticks apart.
- R3: Each frame carries 8 bits, most significant bit first on `sdo`. The first bit appears when the frame loads, and each later bit appears at a falling `sclk` edge.
- R4: `sdi` is sampled at every rising `sclk` edge. The received byte is assembled with the first sampled bit as its most significant bit.
- R5: Register map selected by `addr`:
  - 0 is data: a write loads the transmit buffer and a read returns the receive buffer.
  - 1 is control: bit 0 enables the shifter.
  - 2 is status, with these bits:
    - bit 0: receive full
    - bit 1: transmit empty
    - bit 2: done
    - bit 3: overrun
    - bit 4: shifter busy
  - 3 is the interrupt mask: bit 0 receive, bit 1 transmit empty, bit 2 done.
- R6: When a frame ends and the transmit buffer holds a byte, that byte loads at once. The first rising edge of the next frame comes two ticks after the previous frame's last rising edge, so there is no gap.
- R7: Done sets only when the last bit of a frame has shifted and the transmit buffer is empty. A write to the data address clears it.
- R8: A read of the data address clears receive full. If a frame completes while receive full is still set, the receive buffer is overwritten and overrun sets. Writing a 1 to status bit 3 clears overrun.
- R9: Each interrupt output equals its status flag ANDed with its mask bit, registered one cycle later. A cleared mask bit holds its output low.
- R10: Clearing the enable bit aborts the current frame. `sclk` is low one cycle later, and the aborted frame sets neither receive full nor done.
- R11: After reset, status reads 0x02, control and mask read 0, and `sclk`, `sdo` and all interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Bit-rate clock enable; each pulse toggles `sclk` during a frame |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effects on data address) |
| addr | input | 2 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| sclk | output | 1 | Serial clock driven by this master |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| irq_rx_full | output | 1 | Masked receive-full interrupt |
| irq_tx_empty | output | 1 | Masked transmit-empty interrupt |
| irq_tx_done | output | 1 | Masked transmission-done interrupt |

## Verification
The port is driven in several ways:
- A lone byte with a steady tick separates transmit ordering, receive assembly and the done flag from any streaming effects.
- A stream of random bytes with randomly spaced ticks shows whether hand-over is gap-free: a gap or a stretched bit shows up in the tick spacing between rising edges across byte boundaries.
- Two frames with no read between them separate overwrite-and-overrun from normal receive.
- A masked run and a half-masked run separate flag state from interrupt gating.
- An abort mid-frame, followed by a fresh byte, shows that the abort leaves no stale event and no stale bit count.

// File: rtl/ssm_pkg.sv
// Package: shared register selects and status bit positions for the
// double-buffered serial master. Assumes an 8-bit-or-wider register port.
package ssm_pkg;
    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_STAT = 2'd2,
        SEL_MASK = 2'd3
    } reg_sel_e;

    localparam int FLG_RXF  = 0;
    localparam int FLG_TXE  = 1;
    localparam int FLG_DONE = 2;
    localparam int FLG_OVR  = 3;
    localparam int FLG_BUSY = 4;
    localparam int NUM_IRQ  = 3;
    localparam int NUM_FLG  = 5;
endpackage

// File: rtl/ssm_shifter.sv
// Shifter: generates the half-rate serial clock from the tick enable and
// moves one frame at a time. Outputs on the falling edge, samples on the
// rising edge, idles low. Assumes the transmit buffer is held stable by the
// register block until take_tx pulses.
module ssm_shifter #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          enable,
    input  logic          tx_valid,
    input  logic [DW-1:0] tx_byte,
    input  logic          sdi,
    output logic          sclk,
    output logic          sdo,
    output logic          busy,
    output logic          take_tx,
    output logic          frame_done,
    output logic          went_idle,
    output logic [DW-1:0] rx_byte
);
    localparam int CW = (DW > 1) ? $clog2(DW) : 1;
    localparam logic [CW-1:0] LAST = CW'(DW - 1);

    logic          active_q;
    logic          sclk_q;
    logic          samp_q;
    logic [DW-1:0] sr_q;
    logic [CW-1:0] cnt_q;
    logic          fall_now;
    logic          last_bit;

    // Decode of the current edge and hand-over events.
    always_comb begin
        last_bit   = (cnt_q == LAST);
        fall_now   = enable && active_q && tick && sclk_q;
        frame_done = fall_now && last_bit;
        went_idle  = frame_done && !tx_valid;
        take_tx    = enable && tx_valid && (!active_q || frame_done);
        rx_byte    = {sr_q[DW-2:0], samp_q};
    end

    // Frame sequencing: load, rise/sample, fall/shift, reload or stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            sclk_q   <= 1'b0;
            samp_q   <= 1'b0;
            sr_q     <= '0;
            cnt_q    <= '0;
        end else if (!enable) begin
            active_q <= 1'b0;
            sclk_q   <= 1'b0;
            cnt_q    <= '0;
        end else if (!active_q) begin
            if (tx_valid) begin
                active_q <= 1'b1;
                sr_q     <= tx_byte;
                cnt_q    <= '0;
                sclk_q   <= 1'b0;
            end
        end else if (tick) begin
            if (!sclk_q) begin
                sclk_q <= 1'b1;
                samp_q <= sdi;
            end else begin
                sclk_q <= 1'b0;
                if (last_bit) begin
                    cnt_q <= '0;
                    if (tx_valid) begin
                        sr_q <= tx_byte;
                    end else begin
                        active_q <= 1'b0;
                    end
                end else begin
                    sr_q  <= {sr_q[DW-2:0], samp_q};
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    // Line outputs: data is only driven while a frame is running.
    always_comb begin
        sclk = sclk_q;
        sdo  = active_q & sr_q[DW-1];
        busy = active_q;
    end
endmodule

// File: rtl/ssm_regs.sv
// Register block: holds control, mask, both holding buffers and the status
// flags; applies the shared data-address read/write semantics. Assumes
// single-cycle strobes from the bus side.
module ssm_regs
    import ssm_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [1:0]         addr,
    input  logic [DW-1:0]      wdata,
    output logic [DW-1:0]      rdata,
    input  logic               take_tx,
    input  logic               frame_done,
    input  logic               went_idle,
    input  logic               busy,
    input  logic [DW-1:0]      rx_byte,
    output logic               enable,
    output logic               tx_valid,
    output logic [DW-1:0]      tx_byte,
    output logic [NUM_FLG-1:0] flags,
    output logic [DW-1:0]      mask
);
    logic [DW-1:0] ctrl_q;
    logic [DW-1:0] mask_q;
    logic [DW-1:0] txb_q;
    logic [DW-1:0] rxb_q;
    logic          txf_q;
    logic          rxf_q;
    logic          done_q;
    logic          ovr_q;
    logic          wr_data;
    logic          rd_data;
    logic          wr_stat;

    // Address decode of the bus strobes.
    always_comb begin
        wr_data = wr_en && (addr == SEL_DATA);
        rd_data = rd_en && (addr == SEL_DATA);
        wr_stat = wr_en && (addr == SEL_STAT);
    end

    // Control and mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            mask_q <= '0;
        end else if (wr_en) begin
            if (addr == SEL_CTRL) ctrl_q <= wdata;
            if (addr == SEL_MASK) mask_q <= wdata;
        end
    end

    // Transmit holding buffer: a write wins over a same-cycle hand-over.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txb_q <= '0;
            txf_q <= 1'b0;
        end else if (wr_data) begin
            txb_q <= wdata;
            txf_q <= 1'b1;
        end else if (take_tx) begin
            txf_q <= 1'b0;
        end
    end

    // Receive holding buffer, receive-full and overrun flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxb_q <= '0;
            rxf_q <= 1'b0;
            ovr_q <= 1'b0;
        end else begin
            if (frame_done) begin
                rxb_q <= rx_byte;
                rxf_q <= 1'b1;
            end else if (rd_data) begin
                rxf_q <= 1'b0;
            end
            if (frame_done && rxf_q && !rd_data) begin
                ovr_q <= 1'b1;
            end else if (wr_stat && wdata[FLG_OVR]) begin
                ovr_q <= 1'b0;
            end
        end
    end

    // End-of-transmission flag: set when the shifter goes idle, cleared by a data write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else if (wr_data) begin
            done_q <= 1'b0;
        end else if (went_idle) begin
            done_q <= 1'b1;
        end
    end

    // Flag vector and outward views of the registers.
    always_comb begin
        flags           = '0;
        flags[FLG_RXF]  = rxf_q;
        flags[FLG_TXE]  = !txf_q;
        flags[FLG_DONE] = done_q;
        flags[FLG_OVR]  = ovr_q;
        flags[FLG_BUSY] = busy;
        enable          = ctrl_q[0];
        tx_valid        = txf_q;
        tx_byte         = txb_q;
        mask            = mask_q;
    end

    // Read multiplexer.
    always_comb begin
        rdata = '0;
        unique case (reg_sel_e'(addr))
            SEL_DATA: rdata = rxb_q;
            SEL_CTRL: rdata = ctrl_q;
            SEL_STAT: rdata[NUM_FLG-1:0] = flags;
            SEL_MASK: rdata = mask_q;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/ssm_irq.sv
// Interrupt gating: one registered AND of flag and mask per source.
// Assumes flags are already synchronous to clk.
module ssm_irq #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] flag,
    input  logic [N-1:0] en,
    output logic [N-1:0] irq
);
    for (genvar i = 0; i < N; i++) begin : g_src
        logic q;
        // Registered gate for source i.
        always_ff @(posedge clk) begin
            if (!rst_n) q <= 1'b0;
            else        q <= flag[i] & en[i];
        end
        assign irq[i] = q;
    end
endmodule

// File: rtl/ssm_top.sv
// Top: double-buffered full-duplex serial master. Wires the register block,
// the shifter and the interrupt gates together. Assumes tick is a
// single-cycle enable synchronous to clk.
module ssm_top
    import ssm_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [1:0]    addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          sclk,
    output logic          sdo,
    input  logic          sdi,
    output logic          irq_rx_full,
    output logic          irq_tx_empty,
    output logic          irq_tx_done
);
    logic               ctrl_en;
    logic               sh_busy;
    logic               take_tx;
    logic               frame_done;
    logic               went_idle;
    logic               tx_valid;
    logic [DW-1:0]      tx_byte;
    logic [DW-1:0]      rx_byte;
    logic [DW-1:0]      mask_q;
    logic [NUM_FLG-1:0] stat_flags;
    logic [NUM_IRQ-1:0] irq_vec;

    ssm_regs #(.DW(DW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .addr       (addr),
        .wdata      (wdata),
        .rdata      (rdata),
        .take_tx    (take_tx),
        .frame_done (frame_done),
        .went_idle  (went_idle),
        .busy       (sh_busy),
        .rx_byte    (rx_byte),
        .enable     (ctrl_en),
        .tx_valid   (tx_valid),
        .tx_byte    (tx_byte),
        .flags      (stat_flags),
        .mask       (mask_q)
    );

    ssm_shifter #(.DW(DW)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .enable     (ctrl_en),
        .tx_valid   (tx_valid),
        .tx_byte    (tx_byte),
        .sdi        (sdi),
        .sclk       (sclk),
        .sdo        (sdo),
        .busy       (sh_busy),
        .take_tx    (take_tx),
        .frame_done (frame_done),
        .went_idle  (went_idle),
        .rx_byte    (rx_byte)
    );

    ssm_irq #(.N(NUM_IRQ)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .flag  (stat_flags[NUM_IRQ-1:0]),
        .en    (mask_q[NUM_IRQ-1:0]),
        .irq   (irq_vec)
    );

    // Interrupt lines in flag order.
    always_comb begin
        irq_rx_full  = irq_vec[FLG_RXF];
        irq_tx_empty = irq_vec[FLG_TXE];
        irq_tx_done  = irq_vec[FLG_DONE];
    end
endmodule

// File: rtl/ssm_chk.sv
// Checker: temporal properties of the serial master, bound into ssm_top.
module ssm_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       sclk,
    input logic       enable,
    input logic       busy,
    input logic [4:0] flags
);
    AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> $past(tick)); // R2
    AST_RISE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> $past(busy)); // R1
    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !sclk); // R10
    AST_DONE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[2]) |-> flags[1]); // R7
    AST_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[3]) |-> $past(flags[0])); // R8
endmodule

bind ssm_top ssm_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .sclk   (sclk),
    .enable (ctrl_en),
    .busy   (sh_busy),
    .flags  (stat_flags)
);

// File: tb/tb_ssm_top.sv
module tb_ssm_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       sclk, sdo, sdi;
    logic       irq_rx_full, irq_tx_empty, irq_tx_done;

    int checks = 0;
    int errors = 0;
    int tick_mode = 0;
    int tick_cnt = 0;
    int sptr = 0;
    int cap_cnt = 0;
    int rx_idx = 0;
    bit finished = 1'b0;
    logic [7:0] cap [0:63];
    int rise_tick [0:511];

    ssm_top dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .sclk(sclk), .sdo(sdo),
        .sdi(sdi), .irq_rx_full(irq_rx_full), .irq_tx_empty(irq_tx_empty),
        .irq_tx_done(irq_tx_done)
    );

    always #10 clk = ~clk;

    // Byte the slave model returns in frame i.
    function automatic logic [7:0] sbyte(int i);
        return 8'((i * 53 + 17) ^ (i << 3) ^ 8'hC3);
    endfunction

    function automatic logic sbit(int p);
        logic [7:0] b;
        b = sbyte(p / 8);
        return b[7 - (p % 8)];
    endfunction

    assign sdi = sbit(sptr);

    always @(negedge clk) begin
        if (tick_mode == 0) tick <= 1'b1;
        else                tick <= ($urandom % 3) == 0;
    end

    always @(posedge clk) if (rst_n && tick) tick_cnt++;

    always @(negedge sclk) if (rst_n) sptr++;

    always @(posedge sclk) begin
        if (cap_cnt < 512) begin
            cap[cap_cnt / 8][7 - (cap_cnt % 8)] = sdo;
            rise_tick[cap_cnt] = tick_cnt;
        end
        cap_cnt++;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    // Poll status until bit b equals v; optionally drain the receive buffer.
    task automatic wait_flag(input int b, input logic v, input bit serve, output logic [7:0] st);
        logic [7:0] d;
        for (int i = 0; i < 5000; i++) begin
            bus_rd(2'd2, st);
            if (serve && st[0]) begin
                bus_rd(2'd0, d);
                chk("R4", d, sbyte(rx_idx), "streamed receive byte");
                rx_idx++;
                bus_rd(2'd2, st);
            end
            if (st[b] === v) return;
        end
        chk("R6", 0, 1, "status poll timeout");
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [7:0] st, d;
        logic [7:0] txs [0:7];
        int base, bad, early_done;
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // Reset state
        bus_rd(2'd2, st); chk("R11", st, 8'h02, "status after reset");
        bus_rd(2'd1, d);  chk("R11", d, 8'h00, "control after reset");
        bus_rd(2'd3, d);  chk("R11", d, 8'h00, "mask after reset");
        chk("R11", {sclk, sdo, irq_rx_full, irq_tx_empty, irq_tx_done}, 0, "lines after reset");

        // Single byte, steady tick
        tick_mode = 0;
        bus_wr(2'd3, 8'h07);
        bus_wr(2'd1, 8'h01);
        bus_rd(2'd1, d); chk("R5", d, 8'h01, "control readback");
        bus_wr(2'd0, 8'hA5);
        wait_flag(2, 1'b1, 1'b0, st);
        chk("R7", st & 8'h1F, 8'h07, "status after single byte");
        chk("R3", cap[0], 8'hA5, "single byte on sdo MSB first");
        chk("R9", {irq_rx_full, irq_tx_empty, irq_tx_done}, 3'b111, "irqs with full mask");
        bus_rd(2'd0, d); chk("R4", d, sbyte(0), "single received byte");
        bus_rd(2'd2, st); chk("R8", st & 8'h01, 0, "receive full cleared by read");
        chk("R1", sclk, 0, "sclk idles low");
        bus_wr(2'd0, 8'h3C);
        bus_rd(2'd2, st); chk("R7", st & 8'h04, 0, "done cleared by data write");
        wait_flag(2, 1'b1, 1'b0, st);
        chk("R3", cap[1], 8'h3C, "second byte on sdo");
        bus_rd(2'd0, d); chk("R4", d, sbyte(1), "second received byte");
        rx_idx = 2;

        // Random stream with random tick spacing
        tick_mode = 1;
        base = cap_cnt / 8;
        early_done = 0;
        for (int i = 0; i < 8; i++) begin
            txs[i] = 8'($urandom);
            wait_flag(1, 1'b1, 1'b1, st);
            if (i > 0 && st[2]) early_done++;
            if (st[3]) early_done += 100;
            bus_wr(2'd0, txs[i]);
        end
        wait_flag(2, 1'b1, 1'b1, st);
        wait_flag(0, 1'b0, 1'b1, st);
        chk("R7", early_done, 0, "no done or overrun inside stream");
        for (int i = 0; i < 8; i++) chk("R3", cap[base + i], txs[i], "streamed byte on sdo");
        chk("R4", rx_idx, 10, "all streamed bytes received");
        bad = 0;
        for (int k = base * 8; k < (base + 8) * 8 - 1; k++)
            if (rise_tick[k + 1] - rise_tick[k] != 2) bad++;
        chk("R6", bad, 0, "rising edges two ticks apart across bytes (R2)");

        // Overrun: two frames without reading
        tick_mode = 0;
        bus_wr(2'd0, 8'h11);
        wait_flag(2, 1'b1, 1'b0, st);
        bus_wr(2'd0, 8'h22);
        wait_flag(2, 1'b1, 1'b0, st);
        chk("R8", st & 8'h09, 8'h09, "overrun and receive full set");
        bus_rd(2'd0, d); chk("R8", d, sbyte(rx_idx + 1), "receive buffer overwritten");
        rx_idx += 2;
        bus_wr(2'd2, 8'h08);
        bus_rd(2'd2, st); chk("R8", st & 8'h08, 0, "overrun cleared by write-one");

        // Masking
        bus_wr(2'd3, 8'h00);
        bus_wr(2'd0, 8'h5A);
        wait_flag(2, 1'b1, 1'b0, st);
        bus_rd(2'd2, st);
        chk("R9", {st[0], irq_rx_full, irq_tx_empty, irq_tx_done}, 4'b1000, "masked irqs low");
        bus_wr(2'd3, 8'h01);
        @(negedge clk);
        chk("R9", {irq_rx_full, irq_tx_empty, irq_tx_done}, 3'b100, "receive irq only");
        bus_rd(2'd0, d); chk("R4", d, sbyte(rx_idx), "masked-run byte");

        // Abort mid-frame
        base = cap_cnt;
        bus_wr(2'd0, 8'hF0);
        for (int i = 0; i < 200 && cap_cnt < base + 3; i++) @(negedge clk);
        bus_wr(2'd1, 8'h00);
        @(negedge clk);
        chk("R10", sclk, 0, "sclk low after abort");
        bad = 0;
        for (int i = 0; i < 20; i++) begin @(negedge clk); if (sclk) bad++; end
        chk("R10", bad, 0, "sclk stays low while disabled");
        bus_rd(2'd2, st); chk("R10", st & 8'h15, 0, "no receive, done or busy after abort");

        // Re-enable from a clean alignment
        sptr = 0; cap_cnt = 0; rx_idx = 0;
        bus_wr(2'd1, 8'h01);
        bus_wr(2'd0, 8'hC7);
        wait_flag(2, 1'b1, 1'b0, st);
        chk("R10", cap[0], 8'hC7, "fresh frame after abort");
        bus_rd(2'd0, d); chk("R4", d, sbyte(0), "fresh received byte");

        summary();
    end
endmodule